// File: doc/BRIEF.md
# Narrow-to-Wide AXI4 Read Burst Adapter

This block connects a 32-bit AXI4 read master to a 128-bit AXI4 read port of a memory controller. It takes one narrow INCR read request and turns it into a single wide burst. The wide address is aligned down to a 16-byte boundary. The wide length is rounded up so that the burst covers every 32-bit word that was requested.

The returned 128-bit beats are split into 32-bit words and delivered in ascending lane order. Delivery starts at the lane selected by the request's start address. Any lanes in the last wide word that lie past the requested words are dropped. The adapter generates the narrow last flag itself, and it copies each wide beat's response code onto every narrow beat taken from that wide beat.

Only one burst is in flight at a time. The master must not issue a request that crosses a 4 KB boundary. The start address may fall on any of the four lanes, and the length may be any value from 1 to 256 words.

Top module: `axi_rd_downsizer`

## Requirements
- R1: After reset, s_arready is 1, m_arvalid is 0 and s_rvalid is 0.
- R2: The wide request address equals the narrow request address with bits [3:0] cleared.
- R3: The wide m_arlen equals (off + s_arlen) >> 2, where off is s_araddr[3:2]. The number of wide beats is therefore ceil((off + N) / 4), with N = s_arlen + 1.
- R4: While m_arvalid is high and m_arready is low, m_arvalid stays high and m_araddr and m_arlen hold their values.
- R5: Narrow beat j of a burst carries the word at byte address s_araddr + 4*j. That word is lane ((off + j) mod 4) of wide beat (off + j) >> 2, where lane k is m_rdata[32k+31:32k]. Narrow beats are delivered in order.
- R6: s_rlast is 1 on narrow beat N-1 and 0 on every earlier beat of the burst.
- R7: A wide beat is consumed (m_rready high) only in the cycle in which its lane 3 or the burst's final word is handed over. No lane is lost under any pattern of s_rready or m_rvalid stalls.
- R8: Every narrow beat carries the s_rresp value of the wide beat it was taken from.
- R9: s_arready is low from the cycle after a request is accepted until the final narrow beat is handed over. It is high again in the cycle that follows that beat.
- R10: A 255-word request at 0x7FFC00 issues 64 wide beats, and a 1-word request at 0x7FFFFC issues 1 wide beat at 0x7FFFF0 and delivers lane 3. Both complete, and a later request is accepted after each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_araddr | input | ADDR_W | Narrow request byte address |
| s_arlen | input | 8 | Narrow burst length minus one |
| s_arvalid | input | 1 | Narrow request valid |
| s_arready | output | 1 | Narrow request accepted |
| s_rdata | output | 32 | Narrow read word |
| s_rresp | output | 2 | Narrow read response |
| s_rlast | output | 1 | Final narrow word of the burst |
| s_rvalid | output | 1 | Narrow read word valid |
| s_rready | input | 1 | Master takes the narrow word |
| m_araddr | output | ADDR_W | Aligned wide request address |
| m_arlen | output | 8 | Wide burst length minus one |
| m_arvalid | output | 1 | Wide request valid |
| m_arready | input | 1 | Wide request accepted |
| m_rdata | input | 128 | Wide read data |
| m_rresp | input | 2 | Wide read response |
| m_rlast | input | 1 | Final wide beat from the controller |
| m_rvalid | input | 1 | Wide read data valid |
| m_rready | output | 1 | Adapter consumes the wide beat |

## Verification
The hardest situation to reach is a wide beat that is only partly drained, with a narrow stall arriving at a lane boundary at the same moment as a wide-side gap. This is where a lane could be lost or a wide beat released too early. The bench reaches it by sweeping every start lane against short lengths and near-maximum lengths. It rotates three stall patterns, in which s_rready and m_rvalid toggle at different periods, so that the two sides fall in and out of phase. The two addresses from R10 are run on their own afterwards.

// File: rtl/axi_rd_downsizer.sv
module axi_rd_downsizer #(
  parameter int ADDR_W = 32,
  parameter int NW     = 32,
  parameter int WW     = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic [7:0]        s_arlen,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [NW-1:0]     s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rlast,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [7:0]        m_arlen,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [WW-1:0]     m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rlast,
  input  logic              m_rvalid,
  output logic              m_rready
);
  localparam int LANES = WW / NW;
  localparam int LW    = $clog2(LANES);
  localparam int BW    = $clog2(NW / 8);
  localparam int WB    = $clog2(WW / 8);

  typedef enum logic [1:0] {IDLE, ADDR, DATA} st_t;
  st_t st;

  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        wlen_q;
  logic [7:0]        left_q;
  logic [LW-1:0]     lane_q;

  wire [LW-1:0] off   = s_araddr[BW+LW-1:BW];
  wire [8:0]    wsum  = {1'b0, s_arlen} + 9'(off);
  wire          ar_hs = s_arvalid && s_arready;
  wire          r_hs  = s_rvalid && s_rready;
  wire          fin   = (left_q == 8'd0);
  wire          wend  = (lane_q == LW'(LANES - 1));

  assign s_arready = (st == IDLE);
  assign m_arvalid = (st == ADDR);
  assign m_araddr  = addr_q;
  assign m_arlen   = wlen_q;
  assign s_rvalid  = (st == DATA) && m_rvalid;
  assign s_rdata   = m_rdata[lane_q*NW +: NW];
  assign s_rresp   = m_rresp;
  assign s_rlast   = fin;
  assign m_rready  = (st == DATA) && s_rready && (fin || wend);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      addr_q <= '0;
      wlen_q <= '0;
      left_q <= '0;
      lane_q <= '0;
    end else begin
      case (st)
        IDLE: if (ar_hs) begin
          addr_q <= {s_araddr[ADDR_W-1:WB], WB'(0)};
          wlen_q <= 8'(wsum >> LW);
          left_q <= s_arlen;
          lane_q <= off;
          st     <= ADDR;
        end
        ADDR: if (m_arready) st <= DATA;
        DATA: if (r_hs) begin
          lane_q <= lane_q + 1'b1;
          left_q <= left_q - 8'd1;
          if (fin) st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  wire unused_ok = m_rlast;
endmodule

// File: rtl/axi_rd_downsizer_chk.sv
module axi_rd_downsizer_chk #(
  parameter int ADDR_W = 32,
  parameter int NW     = 32,
  parameter int WW     = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] s_araddr,
  input logic [7:0]        s_arlen,
  input logic              s_arvalid,
  input logic              s_arready,
  input logic [NW-1:0]     s_rdata,
  input logic [1:0]        s_rresp,
  input logic              s_rlast,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [ADDR_W-1:0] m_araddr,
  input logic [7:0]        m_arlen,
  input logic              m_arvalid,
  input logic              m_arready,
  input logic [WW-1:0]     m_rdata,
  input logic [1:0]        m_rresp,
  input logic              m_rlast,
  input logic              m_rvalid,
  input logic              m_rready
);
  localparam int WB = $clog2(WW / 8);

  logic [7:0] len_q, cnt_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
      cnt_q <= '0;
    end else if (s_arvalid && s_arready) begin
      len_q <= s_arlen;
      cnt_q <= '0;
    end else if (s_rvalid && s_rready) begin
      cnt_q <= cnt_q + 8'd1;
    end
  end

  // R2
  wide_addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid |-> m_araddr[WB-1:0] == '0);
  // R4
  wide_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));
  // R6
  last_on_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> s_rlast == (cnt_q == len_q));
  // R7
  wide_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_rready && m_rvalid |-> s_rvalid && s_rready);
  // R8
  resp_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid |-> s_rresp == m_rresp);
  // R9
  single_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_arvalid && s_arready |=> !s_arready);
  // R9
  reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && s_rready && s_rlast |=> s_arready);
  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_arready && (m_arvalid || s_rvalid)));

  wire unused_c = ^{s_rdata, m_rlast, m_rdata[0]};
endmodule

bind axi_rd_downsizer axi_rd_downsizer_chk #(.ADDR_W(ADDR_W), .NW(NW), .WW(WW)) u_chk (.*);

// File: tb/axi_rd_downsizer_bench.sv
module axi_rd_downsizer_bench;
  logic clk = 0, rst_n = 0;
  logic [31:0] s_araddr = 0; logic [7:0] s_arlen = 0; logic s_arvalid = 0, s_arready;
  logic [31:0] s_rdata; logic [1:0] s_rresp; logic s_rlast, s_rvalid, s_rready = 0;
  logic [31:0] m_araddr; logic [7:0] m_arlen; logic m_arvalid, m_arready = 0;
  logic [127:0] m_rdata = 0; logic [1:0] m_rresp = 0; logic m_rlast = 0, m_rvalid = 0, m_rready;

  int checks = 0, errors = 0, cyc = 0, mode = 0;
  bit done = 0;

  axi_rd_downsizer u_axi_rd_downsizer (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return a ^ 32'hA5C3_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic slave(input logic [31:0] a, input logic [7:0] l);
    int w = 0;
    logic [31:0] ea = {a[31:4], 4'h0};
    logic [7:0]  el = 8'((9'(a[3:2]) + 9'(l)) >> 2);
    logic [31:0] pa = 0; logic [7:0] pl = 0; bit seen = 0;
    forever begin
      @(negedge clk);
      m_arready = (w >= 2);
      #2;
      if (m_arvalid) begin
        if (seen) chk(m_araddr == pa && m_arlen == pl, "R4", m_araddr, pa);
        pa = m_araddr; pl = m_arlen; seen = 1;
        if (m_arready) break;
        w++;
      end
    end
    chk(m_araddr == ea, "R2", m_araddr, ea);
    chk(m_arlen == el, "R3", 32'(m_arlen), 32'(el));
    @(negedge clk); m_arready = 0;
    for (int i = 0; i <= int'(el); ) begin
      if (i != 0 || 1) ;
      m_rvalid = (mode == 1) ? (cyc % 2 == 0) : 1'b1;
      for (int k = 0; k < 4; k++) m_rdata[32*k +: 32] = word_at(ea + 32'(16*i + 4*k));
      m_rresp = 2'(i);
      m_rlast = (i == int'(el));
      #2;
      if (m_rvalid && m_rready) i++;
      if (i <= int'(el)) @(negedge clk);
    end
    @(negedge clk); m_rvalid = 0; m_rlast = 0;
  endtask

  task automatic master(input logic [31:0] a, input logic [7:0] l);
    int n = int'(l) + 1;
    int off = int'(a[3:2]);
    @(negedge clk);
    s_araddr = a; s_arlen = l; s_arvalid = 1;
    #2;
    while (!s_arready) begin @(negedge clk); #2; end
    @(negedge clk); s_arvalid = 0;
    #2; chk(!s_arready, "R9", 32'(s_arready), 0);
    for (int j = 0; j < n; ) begin
      s_rready = (mode == 1) ? (cyc % 3 != 0) : (mode == 2) ? (cyc % 4 == 0) : 1'b1;
      #2;
      if (s_rvalid && s_rready) begin
        logic [31:0] ew = word_at(a + 32'(4*j));
        logic [1:0]  er = 2'((off + j) >> 2);
        chk(s_rdata == ew, "R5", s_rdata, ew);
        chk(s_rresp == er, "R8", 32'(s_rresp), 32'(er));
        chk(s_rlast == (j == n - 1), "R6", 32'(s_rlast), 32'(j == n - 1));
        j++;
      end
      @(negedge clk);
    end
    s_rready = 0;
    #1; chk(s_arready, "R9", 32'(s_arready), 1);
  endtask

  task automatic burst(input logic [31:0] a, input logic [7:0] l);
    fork
      slave(a, l);
      master(a, l);
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(s_arready == 1, "R1", 32'(s_arready), 1);
    chk(m_arvalid == 0, "R1", 32'(m_arvalid), 0);
    chk(s_rvalid == 0, "R1", 32'(s_rvalid), 0);
    for (int o = 0; o < 4; o++) begin
      for (int l = 0; l < 21; l++) begin
        mode = (o + l) % 3;
        burst(32'h0001_0000 + 32'(l * 32'h1000) + 32'(o * 4), 8'(l));
      end
      for (int l = 253; l < 256; l++) begin
        mode = (o + l) % 3;
        burst(32'h0020_0000 + 32'(o * 4), 8'(l));
      end
    end
    // R10 corner cases
    mode = 1;
    burst(32'h007F_FC00, 8'hFE);
    burst(32'h007F_FFFC, 8'h00);
    mode = 2;
    burst(32'h007F_FFFC, 8'h00);
    burst(32'h007F_FC00, 8'hFE);
    chk(s_arready == 1, "R10", 32'(s_arready), 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule